// File: doc/BRIEF.md
# Packed Upper-Half Interleave Unit

This unit is a small execution pipe for packed data. It takes two operands, called destination and source, and keeps only the upper half of each. The elements of those two upper halves are woven together: one element from the destination, then one from the source, and so on. The result can convert narrow unsigned elements into elements twice as wide, because a source of all zeros places a zero above each destination element.

A one-byte opcode picks the element size: byte, word, doubleword or quadword. A width flag picks 64-bit or 128-bit operation. Results come back after two cycles in 64-bit mode and after four cycles in 128-bit mode. Encodings that are not defined raise a flag in place of a result.

One request can be offered each cycle. A small issue-gate state machine blocks any short-latency request that would collide with a long one already in flight, or that would overtake it. Results therefore always leave in the order they were issued. The gate has three states. GATE_OPEN accepts anything. GATE_HOLD_A is entered on a 128-bit issue. GATE_HOLD_B is the second blocked cycle. The transitions are T_WIDE_ISSUE (any state to GATE_HOLD_A when a 128-bit request is accepted), T_AGE (GATE_HOLD_A to GATE_HOLD_B) and T_RELEASE (GATE_HOLD_B to GATE_OPEN). A 64-bit request or an illegal one is short, and it is refused in both hold states.

Top module: `unpack_hi_unit`

## Requirements
- R1: Opcode 8'h68 selects byte elements, 8'h69 word elements, 8'h6A doubleword elements and 8'h6D quadword elements.
- R2: With in_wide=1 the operands are 128 bits wide and their upper half is bits 127:64. With in_wide=0 they are 64 bits wide and their upper half is bits 63:32.
- R3: Element 0 is the least significant element. Result element 2k is the destination's k-th upper-half element, and result element 2k+1 is the source's k-th upper-half element. Lower-half bits of both operands have no effect on the result.
- R4: With an all-zero source, each upper-half destination element appears in the result zero-extended to twice its width.
- R5: In 64-bit mode, bits 127:64 of out_result are zero.
- R6: A legal request accepted at the clock edge ending cycle c gives out_valid=1 for one cycle, in cycle c+2 for 64-bit mode and in cycle c+4 for 128-bit mode.
- R7: Opcode 8'h6D with in_wide=0, or any opcode other than 8'h68, 8'h69, 8'h6A or 8'h6D, is illegal. Accepted at the edge ending cycle c, it gives out_illegal=1 in cycle c+2 with out_valid=0, and out_result stays unchanged.
- R8: in_ready is low exactly when the offered request is short (64-bit or illegal) and a 128-bit request was accepted in either of the two previous cycles. This is checked whether or not in_valid is high. 128-bit requests are always ready, so results leave in issue order.
- R9: After reset out_valid=0, out_illegal=0, out_result=0 and in_ready=1. out_result keeps its last value in every cycle with out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The offered request is accepted this cycle (combinational from opcode and width flag) |
| in_opcode | input | 8 | Operation byte that selects element size |
| in_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | out_result carries a new result this cycle |
| out_illegal | output | 1 | An illegal request completes this cycle |
| out_result | output | 128 | Interleaved result, held between results |

## Verification
The hardest situation to reach is a short request arriving one or two cycles after a 128-bit issue. This is the only case where the gate must refuse work, and where a wrong insertion slot would reorder or overwrite results. The directed part of the stimulus issues a 128-bit request and then offers 64-bit and illegal requests in the next cycles. The random part draws width and opcode independently on most cycles, so back-to-back mixes of long and short requests occur hundreds of times. Illegal completions landing between valid results exercise the rule that the held result is not touched.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int DATA_W     = 128;
    localparam int LAT_NARROW = 2;
    localparam int LAT_WIDE   = 4;

    localparam logic [7:0] OPC_BYTE  = 8'h68;
    localparam logic [7:0] OPC_WORD  = 8'h69;
    localparam logic [7:0] OPC_DWORD = 8'h6A;
    localparam logic [7:0] OPC_QWORD = 8'h6D;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_WORD  = 2'd1,
        ESZ_DWORD = 2'd2,
        ESZ_QWORD = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        GATE_OPEN   = 2'd0,
        GATE_HOLD_A = 2'd1,
        GATE_HOLD_B = 2'd2
    } gate_e;

endpackage

// File: rtl/unpk_decode.sv
module unpk_decode
    import unpk_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       wide,
    output esz_e       esz,
    output logic       illegal,
    output logic       short_lat
);

    always_comb begin
        esz     = ESZ_BYTE;
        illegal = 1'b0;
        case (opcode)
            OPC_BYTE:  esz = ESZ_BYTE;
            OPC_WORD:  esz = ESZ_WORD;
            OPC_DWORD: esz = ESZ_DWORD;
            OPC_QWORD: begin
                esz     = ESZ_QWORD;
                illegal = !wide;      // quadword exists only at full width
            end
            default:   illegal = 1'b1;
        endcase
        short_lat = illegal || !wide;
    end

endmodule

// File: rtl/unpk_interleave.sv
module unpk_interleave
    import unpk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  esz_e          esz,
    input  logic          wide,
    output logic [DW-1:0] res
);

    localparam int QW = DW / 4;   // upper-half width in narrow mode

    logic [DW-1:0] cand [8];
    logic          unused_lo;

    assign unused_lo = ^{dst[QW-1:0], src[QW-1:0]};

    for (genvar md = 0; md < 2; md++) begin : g_mode
        localparam int HW = QW * (md + 1);
        for (genvar sz = 0; sz < 4; sz++) begin : g_size
            localparam int EW = 8 << sz;
            if (EW <= HW) begin : g_ok
                localparam int N = HW / EW;
                logic [2*HW-1:0] pk;
                for (genvar k = 0; k < N; k++) begin : g_elem
                    assign pk[(2*k)*EW   +: EW] = dst[HW + k*EW +: EW];
                    assign pk[(2*k+1)*EW +: EW] = src[HW + k*EW +: EW];
                end
                if (2*HW < DW) begin : g_pad
                    assign cand[md*4+sz] = {{(DW-2*HW){1'b0}}, pk};
                end else begin : g_full
                    assign cand[md*4+sz] = pk;
                end
            end else begin : g_none
                assign cand[md*4+sz] = '0;
            end
        end
    end

    assign res = cand[{wide, esz}];

endmodule

// File: rtl/unpk_issue_fsm.sv
module unpk_issue_fsm
    import unpk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_short,
    input  logic acc_wide,
    output logic ready
);

    gate_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GATE_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (acc_wide) begin
            state_d = GATE_HOLD_A;                 // T_WIDE_ISSUE
        end else begin
            unique case (state_q)
                GATE_OPEN:   state_d = GATE_OPEN;
                GATE_HOLD_A: state_d = GATE_HOLD_B; // T_AGE
                GATE_HOLD_B: state_d = GATE_OPEN;   // T_RELEASE
                default:     state_d = GATE_OPEN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            GATE_OPEN:   ready = 1'b1;
            GATE_HOLD_A,
            GATE_HOLD_B: ready = !req_short;
            default:     ready = 1'b1;
        endcase
    end

    AST_SHORT_BLOCK_1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wide |=> !(req_short && ready)); // R8
    AST_SHORT_BLOCK_2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wide |-> ##2 !(req_short && ready)); // R8
    AST_WIDE_NEVER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_short |-> ready); // R8

endmodule

// File: rtl/unpk_delay_line.sv
module unpk_delay_line
    import unpk_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int LAT_N = LAT_NARROW,
    parameter int LAT_W = LAT_WIDE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_vld,
    input  logic          ins_ill,
    input  logic          ins_short,
    input  logic [DW-1:0] ins_data,
    output logic          head_vld,
    output logic          head_ill,
    output logic [DW-1:0] head_data
);

    localparam int DEPTH = LAT_W;
    localparam int NPOS  = LAT_N - 1;
    localparam int WPOS  = LAT_W - 1;

    logic          vld_q [DEPTH];
    logic          ill_q [DEPTH];
    logic [DW-1:0] dat_q [DEPTH];
    logic          vld_d [DEPTH];
    logic          ill_d [DEPTH];
    logic [DW-1:0] dat_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            vld_d[i] = vld_q[i+1];
            ill_d[i] = ill_q[i+1];
            dat_d[i] = dat_q[i+1];
        end
        vld_d[DEPTH-1] = 1'b0;
        ill_d[DEPTH-1] = 1'b0;
        dat_d[DEPTH-1] = dat_q[DEPTH-1];
        // the head keeps its data unless a legal result moves in
        if (!(vld_q[1] && !ill_q[1])) dat_d[0] = dat_q[0];
        if (ins_vld) begin
            if (ins_short) begin
                vld_d[NPOS] = 1'b1;
                ill_d[NPOS] = ins_ill;
                if (!ins_ill) dat_d[NPOS] = ins_data;
            end else begin
                vld_d[WPOS] = 1'b1;
                ill_d[WPOS] = 1'b0;
                dat_d[WPOS] = ins_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                ill_q[i] <= 1'b0;
                dat_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= vld_d[i];
                ill_q[i] <= ill_d[i];
                dat_q[i] <= dat_d[i];
            end
        end
    end

    assign head_vld  = vld_q[0];
    assign head_ill  = ill_q[0];
    assign head_data = dat_q[0];

    AST_SHORT_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_short) |-> !vld_q[NPOS+1]); // R8
    AST_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && ins_short) |-> !vld_q[WPOS]); // R8

endmodule

// File: rtl/unpack_hi_unit.sv
module unpack_hi_unit
    import unpk_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_opcode,
    input  logic          in_wide,
    input  logic [DW-1:0] in_dst,
    input  logic [DW-1:0] in_src,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [DW-1:0] out_result
);

    esz_e          dec_esz;
    logic          dec_ill;
    logic          dec_short;
    logic          acc;
    logic          acc_wide;
    logic [DW-1:0] lane_res;
    logic          head_vld;
    logic          head_ill;

    unpk_decode u_decode (
        .opcode    (in_opcode),
        .wide      (in_wide),
        .esz       (dec_esz),
        .illegal   (dec_ill),
        .short_lat (dec_short)
    );

    unpk_interleave #(.DW(DW)) u_lanes (
        .dst  (in_dst),
        .src  (in_src),
        .esz  (dec_esz),
        .wide (in_wide),
        .res  (lane_res)
    );

    unpk_issue_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_short (dec_short),
        .acc_wide  (acc_wide),
        .ready     (in_ready)
    );

    assign acc      = in_valid && in_ready;
    assign acc_wide = acc && !dec_short;

    unpk_delay_line #(.DW(DW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_vld   (acc),
        .ins_ill   (dec_ill),
        .ins_short (dec_short),
        .ins_data  (lane_res),
        .head_vld  (head_vld),
        .head_ill  (head_ill),
        .head_data (out_result)
    );

    assign out_valid   = head_vld && !head_ill;
    assign out_illegal = head_vld && head_ill;

    AST_NARROW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_short && !dec_ill) |-> ##2 out_valid); // R6
    AST_WIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wide |-> ##4 out_valid); // R6
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_short && !dec_ill) |-> ##2 (out_result[DW-1:DW/2] == '0)); // R5
    AST_ILLEGAL_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_ill) |-> ##2 (out_illegal && !out_valid)); // R7
    AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_illegal)); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result)); // R9

endmodule

// File: tb/unpack_hi_unit_tb_top.sv
`timescale 1ns/1ps
module unpack_hi_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_opcode = 8'h00;
    logic         in_wide = 1'b0;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_result;

    always #2 clk = ~clk;   // 250 MHz

    unpack_hi_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_wide(in_wide), .in_dst(in_dst), .in_src(in_src),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int cyc = 0;
    int last_long = -10;
    logic [127:0] held = '0;
    bit           sv [8];
    bit           si [8];
    bit           sw [8];
    logic [127:0] sd [8];
    string        st [8];

    function automatic bit is_illegal(input logic [7:0] opc, input bit w);
        if (opc == 8'h6D) return !w;
        return !(opc == 8'h68 || opc == 8'h69 || opc == 8'h6A);
    endfunction

    function automatic logic [127:0] model(input logic [7:0] opc, input bit w,
                                           input logic [127:0] d, input logic [127:0] s);
        logic [127:0] r = '0;
        int ew = (opc == 8'h68) ? 8 : (opc == 8'h69) ? 16 : (opc == 8'h6A) ? 32 : 64;
        int hw = w ? 64 : 32;
        for (int i = 0; i < 2*hw; i++) begin
            int e = i / ew;
            int b = hw + (e / 2) * ew + (i % ew);
            r[i] = (e % 2 == 0) ? d[b] : s[b];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] opc, input bit w,
                        input logic [127:0] d, input logic [127:0] s, input string tag);
        int idx;
        bit sh, ill, exp_rdy;
        @(negedge clk);
        cyc++;
        idx = cyc % 8;
        chk(out_valid == sv[idx], "R6", "out_valid", 128'(out_valid), 128'(sv[idx]));
        chk(out_illegal == si[idx], "R7", "out_illegal", 128'(out_illegal), 128'(si[idx]));
        if (sv[idx]) held = sd[idx];
        chk(out_result == held, sv[idx] ? st[idx] : (si[idx] ? "R7" : "R9"),
            "out_result", out_result, held);
        if (sv[idx] && !sw[idx])
            chk(out_result[127:64] == '0, "R5", "upper result bits", out_result, held);
        sv[idx] = 0; si[idx] = 0; sw[idx] = 0;
        in_valid = v; in_opcode = opc; in_wide = w; in_dst = d; in_src = s;
        #1;
        ill = is_illegal(opc, w);
        sh = ill || !w;
        exp_rdy = !(sh && (cyc - 1 == last_long || cyc - 2 == last_long));
        chk(in_ready == exp_rdy, "R8", "in_ready", 128'(in_ready), 128'(exp_rdy));
        if (v && exp_rdy) begin
            int j = (cyc + (sh ? 2 : 4)) % 8;
            sv[j] = !ill; si[j] = ill; sw[j] = w;
            sd[j] = ill ? '0 : model(opc, w, d, s);
            st[j] = tag;
            if (!sh) last_long = cyc;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h68, 0, '0, '0, "R9");
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [127:0] ramp(input logic [7:0] base);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = base + 8'(i);
        return r;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0] opcs [4];
        opcs[0] = 8'h68; opcs[1] = 8'h69; opcs[2] = 8'h6A; opcs[3] = 8'h6D;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin sv[i] = 0; si[i] = 0; sw[i] = 0; sd[i] = '0; st[i] = ""; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(out_valid == 0, "R9", "reset out_valid", 128'(out_valid), 0);
        chk(out_illegal == 0, "R9", "reset out_illegal", 128'(out_illegal), 0);
        chk(out_result == '0, "R9", "reset out_result", out_result, 0);
        chk(in_ready == 1, "R9", "reset in_ready", 128'(in_ready), 1);

        // R1 R2 R3: every legal opcode at both widths, isolated
        for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++) begin
                step(1, opcs[o], w[0], ramp(8'h00), ramp(8'h80), "R1 R2 R3");
                idle(4);
            end
        // R3: lower halves must not matter
        step(1, 8'h69, 1, {64'h1111_2222_3333_4444, 64'hDEAD_BEEF_DEAD_BEEF},
                         {64'h5555_6666_7777_8888, 64'hFFFF_FFFF_FFFF_FFFF}, "R3");
        step(1, 8'h68, 0, {64'h0, 32'hA1B2C3D4, 32'h99999999},
                          {64'h0, 32'h01020304, 32'h77777777}, "R3");
        idle(4);
        // R4: zero source gives zero extension
        for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++)
                if (!(o == 3 && w == 0)) begin
                    step(1, opcs[o], w[0], ramp(8'h40), '0, "R4");
                    idle(4);
                end
        // R7: illegal encodings leave result held
        step(1, 8'h6A, 1, rnd128(), rnd128(), "R7");
        step(1, 8'h6D, 0, rnd128(), rnd128(), "R7");
        step(1, 8'h6B, 1, rnd128(), rnd128(), "R7");
        step(1, 8'h00, 0, rnd128(), rnd128(), "R7");
        idle(5);
        // R8: short requests right after a wide issue are refused
        step(1, 8'h68, 1, rnd128(), rnd128(), "R8");
        step(1, 8'h69, 0, rnd128(), rnd128(), "R8");
        step(1, 8'h6C, 1, rnd128(), rnd128(), "R8");
        step(1, 8'h6A, 0, rnd128(), rnd128(), "R8");
        step(1, 8'h6D, 1, rnd128(), rnd128(), "R8");
        step(1, 8'h6D, 1, rnd128(), rnd128(), "R8");
        step(1, 8'h68, 0, rnd128(), rnd128(), "R8");
        step(1, 8'h68, 0, rnd128(), rnd128(), "R8");
        step(1, 8'h68, 0, rnd128(), rnd128(), "R8");
        step(1, 8'h69, 0, rnd128(), rnd128(), "R8");
        idle(5);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int pick = $urandom_range(0, 9);
            logic [7:0] opc = (pick < 9) ? opcs[pick % 4] : 8'($urandom);
            bit v = ($urandom_range(0, 9) < 7);
            bit w = $urandom_range(0, 1) == 1;
            logic [127:0] s = ($urandom_range(0, 7) == 0) ? '0 : rnd128();
            step(v, opc, w, rnd128(), s, "R1 R2 R3");
        end
        idle(6);
        summary();
    end

endmodule